// File: doc/BRIEF.md
# Clear-on-read interrupt status hub

This block collects interrupt requests from eight neighbouring sub-blocks into a single status byte and holds a shared control byte with reset outputs for those sub-blocks. Software reaches both bytes through a minimal synchronous register port: a one-cycle read or write strobe, a one-bit register select and eight data bits. Read data comes back in the same cycle as the read strobe.

Each status bit is set by a rising edge on its source while that source is enabled. Any read of the status byte clears all of its bits. Because a bit is set only by an edge, a source that stays high after a clearing read does not set its bit again. It must fall and rise once more. A force bit in the control byte sets every enabled status bit for as long as it is held. A single interrupt line reports whether any status bit is set.

The asynchronous active-low reset input is released to the logic through a two-stage synchronizer.

Top module: `irq_status_hub`

## Requirements
- R1: After reset, the control byte and the status byte both read 0x00. The interrupt line and all reset and spare outputs are low.
- R2: Status bit layout, from bit 7 down to bit 0: serial link, memory controller non-FIFO, memory controller FIFO, dual-port RAM FIFO banks, interface B core source 2, interface B core source 1, interface A core source 2, interface A core source 1. `src_irq[i]` and `src_en[i]` feed status bit i. A 0-to-1 change on an enabled source sets its bit one clock later.
- R3: A source whose `src_en` bit is 0 never sets its status bit, even when it rises.
- R4: A read with `reg_sel`=1 returns the status byte in the same cycle. All status bits are 0 from the next clock, except bits being set in that same cycle.
- R5: After a clear, a bit stays 0 while its source stays high. It sets again only after the source goes low and then high again.
- R6: A rising edge in the same cycle as a clearing read wins. The read returns the old value, and the bit is 1 on the next clock.
- R7: `irq_o` is high exactly when at least one status bit is set. It falls on the clock after a clearing read unless a new edge arrives.
- R8: Control byte (`reg_sel`=0) layout:
  - bit 0 drives `link_hard_rst_o`;
  - bit 1 drives `mem_soft_rst_o`;
  - bit 2 drives `ifa_soft_rst_o`;
  - bit 3 drives `ifb_soft_rst_o`;
  - bits 5:4 drive `spare_o` and are plain read/write storage.

  A 1 applies the reset, and every written value reads back.
- R9: Control bit 6 is reserved and always reads 0, whatever is written to it.
- R10: Control bit 7 is the force bit. From the second clock after it is written to 1, every enabled status bit is 1, and reads do not clear them while force is held. Disabled bits stay 0. After force is cleared, the bits remain set until the next status read.
- R11: A write with `reg_sel`=1 has no effect on the status byte or the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_sel | input | 1 | 0 selects the control byte, 1 selects the status byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle, 0 when no read |
| src_irq | input | 8 | Interrupt sources, synchronous to clk |
| src_en | input | 8 | Per-source enables |
| irq_o | output | 1 | OR of all status bits |
| link_hard_rst_o | output | 1 | Hard reset for the serial link block |
| mem_soft_rst_o | output | 1 | Soft reset for the memory controller |
| ifa_soft_rst_o | output | 1 | Soft reset for interface A |
| ifb_soft_rst_o | output | 1 | Soft reset for interface B |
| spare_o | output | 2 | Spare control bits |

## Verification
- Read data is combinational, so it is checked in the same cycle as the read strobe.
- A source edge, a clearing read and a control write each take effect one clock later.
- The force bit reaches the status byte one clock after that, so two clocks after its write.
- The bench drives every input just after a falling edge and samples outputs 1 ns later. A check of a registered result therefore lands in the cycle after its stimulus, with exactly one rising edge in between, and the force and release checks wait the extra clock.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int NUM_SRC = 8;
  localparam int DATA_W  = 8;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  // control byte field positions
  localparam int CTRL_HARD  = 0;
  localparam int CTRL_SMEM  = 1;
  localparam int CTRL_SIFA  = 2;
  localparam int CTRL_SIFB  = 3;
  localparam int CTRL_SPARE = 4;
  localparam int SPARE_W    = 2;
  localparam int CTRL_RSVD  = 6;
  localparam int CTRL_FORCE = 7;

  localparam logic [DATA_W-1:0] CTRL_WMASK = ~(DATA_W'(1) << CTRL_RSVD);

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int              WIDTH = 8,
  parameter logic [WIDTH-1:0] WMASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] ctrl_q
);

  logic [WIDTH-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/irq_status_cell.sv
module irq_status_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic en_i,
  input  logic force_i,
  input  logic clr_i,
  output logic stat_o
);

  logic src_q;
  logic stat_q;
  logic stat_d;
  logic rise;
  logic set;

  always_comb begin
    rise   = src_i & ~src_q;
    set    = en_i & (rise | force_i);
    // a set in the clearing cycle wins so no event is lost
    stat_d = set | (stat_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      src_q  <= src_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
  import irq_hub_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic                   reg_sel,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  input  logic [NUM_SRC-1:0]     src_irq,
  input  logic [NUM_SRC-1:0]     src_en,
  output logic                   irq_o,
  output logic                   link_hard_rst_o,
  output logic                   mem_soft_rst_o,
  output logic                   ifa_soft_rst_o,
  output logic                   ifb_soft_rst_o,
  output logic [SPARE_W-1:0]     spare_o
);

  logic               rst_int_n;
  logic [DATA_W-1:0]  ctrl_q;
  logic [NUM_SRC-1:0] status_q;
  logic               ctrl_wr;
  logic               stat_clr;
  logic               force_on;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  assign ctrl_wr  = reg_wr & (reg_sel == SEL_CTRL);
  assign stat_clr = reg_rd & (reg_sel == SEL_STAT);

  irq_ctrl_reg #(.WIDTH(DATA_W), .WMASK(CTRL_WMASK)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (ctrl_wr),
    .wdata  (reg_wdata),
    .ctrl_q (ctrl_q)
  );

  assign force_on = ctrl_q[CTRL_FORCE];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    irq_status_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .src_i   (src_irq[g]),
      .en_i    (src_en[g]),
      .force_i (force_on),
      .clr_i   (stat_clr),
      .stat_o  (status_q[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_sel == SEL_STAT) reg_rdata = DATA_W'(status_q);
      else                     reg_rdata = ctrl_q;
    end
  end

  assign irq_o           = |status_q;
  assign link_hard_rst_o = ctrl_q[CTRL_HARD];
  assign mem_soft_rst_o  = ctrl_q[CTRL_SMEM];
  assign ifa_soft_rst_o  = ctrl_q[CTRL_SIFA];
  assign ifb_soft_rst_o  = ctrl_q[CTRL_SIFB];
  assign spare_o         = ctrl_q[CTRL_SPARE +: SPARE_W];

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_rd,
  input logic               reg_sel,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [NUM_SRC-1:0] src_irq,
  input logic [NUM_SRC-1:0] src_en,
  input logic               irq_o,
  input logic               force_on,
  input logic [NUM_SRC-1:0] status_q
);

  logic [NUM_SRC-1:0] src_prev;
  logic [NUM_SRC-1:0] new_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev <= '0;
    else        src_prev <= src_irq;
  end

  assign new_edge = src_irq & ~src_prev & src_en;

  // R3: a disabled source never sets its bit
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en != '1) |=> ((status_q & ~$past(status_q) & ~$past(src_en)) == '0));

  // R4: a clearing read with no new edge and no force empties the byte
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel && !force_on && new_edge == '0) |=> (status_q == '0));

  // R7: the interrupt line falls after such a read
  a_r7_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel && !force_on && new_edge == '0) |=> !irq_o);

  // R5: a clear bit whose source was already high stays clear
  a_r5_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    !force_on |=> ((status_q & $past(~status_q & src_prev)) == '0));

  // R6: an edge in a clearing cycle survives
  a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel && new_edge != '0) |=>
      ((status_q & $past(new_edge)) == $past(new_edge)));

  // R10: force keeps every enabled bit set
  a_r10_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |=> ((status_q & $past(src_en)) == $past(src_en)));

  // R9: reserved control bit reads zero
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_sel) |-> !reg_rdata[CTRL_RSVD]);

endmodule

bind irq_status_hub irq_hub_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .reg_rd    (reg_rd),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .src_irq   (src_irq),
  .src_en    (src_en),
  .irq_o     (irq_o),
  .force_on  (force_on),
  .status_q  (status_q)
);

// File: tb/tb_irq_status_hub.sv
`timescale 1ns/1ps
module tb_irq_status_hub;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic       reg_rd;
  logic       reg_sel;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [7:0] src_irq;
  logic [7:0] src_en;
  logic       irq_o;
  logic       link_hard_rst_o;
  logic       mem_soft_rst_o;
  logic       ifa_soft_rst_o;
  logic       ifb_soft_rst_o;
  logic [1:0] spare_o;

  int  n_checks;
  int  n_fails;
  bit  done;

  logic [7:0] vsrc;
  logic [7:0] ven;
  logic [7:0] vexp;

  // {source pattern, enables, expected status}
  localparam logic [23:0] VEC [0:5] = '{
    24'h80FF80,
    24'h01FF01,
    24'hA5FFA5,
    24'hFF0F0F,
    24'h3CC300,
    24'hFFFFFF
  };

  irq_status_hub dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_wr          (reg_wr),
    .reg_rd          (reg_rd),
    .reg_sel         (reg_sel),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .src_irq         (src_irq),
    .src_en          (src_en),
    .irq_o           (irq_o),
    .link_hard_rst_o (link_hard_rst_o),
    .mem_soft_rst_o  (mem_soft_rst_o),
    .ifa_soft_rst_o  (ifa_soft_rst_o),
    .ifb_soft_rst_o  (ifb_soft_rst_o),
    .spare_o         (spare_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive after a falling edge, leave 1 ns for combinational outputs
  task automatic op(input logic rd, input logic wr, input logic sel, input logic [7:0] wd);
    @(negedge clk);
    reg_rd    = rd;
    reg_wr    = wr;
    reg_sel   = sel;
    reg_wdata = wd;
    #1;
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  function automatic logic [7:0] ctl_pins();
    return {2'b00, link_hard_rst_o, mem_soft_rst_o, ifa_soft_rst_o, ifb_soft_rst_o, spare_o};
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fails = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 1'b0;
    reg_wdata = '0; src_irq = '0; src_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    check("R1 pins", ctl_pins(), 8'h00);
    op(1'b1, 1'b0, 1'b0, 8'h00); check("R1 ctrl", reg_rdata, 8'h00);
    op(1'b1, 1'b0, 1'b1, 8'h00); check("R1 status", reg_rdata, 8'h00);

    // vector table: R2, R3, R4, R5, R7
    for (int i = 0; i < 6; i++) begin
      vsrc = VEC[i][23:16]; ven = VEC[i][15:8]; vexp = VEC[i][7:0];
      src_irq = '0; src_en = ven;
      idle(); idle();
      src_irq = vsrc;
      op(1'b1, 1'b0, 1'b1, 8'h00);
      check("R2 R3 R4 status", reg_rdata, vexp);
      check("R7 irq high", {7'd0, irq_o}, {7'd0, |vexp});
      idle();
      check("R7 irq drop", {7'd0, irq_o}, 8'h00);
      op(1'b1, 1'b0, 1'b1, 8'h00);
      check("R5 held source", reg_rdata, 8'h00);
      src_irq = '0;
    end

    // R5 re-arm after drop and rise
    src_en = 8'hFF; src_irq = '0;
    idle(); idle();
    src_irq = 8'h02;
    op(1'b1, 1'b0, 1'b1, 8'h00); check("R5 first", reg_rdata, 8'h02);
    idle();
    src_irq = 8'h00;
    idle();
    src_irq = 8'h02;
    op(1'b1, 1'b0, 1'b1, 8'h00); check("R5 rearm", reg_rdata, 8'h02);
    src_irq = 8'h00;
    idle();

    // R6 edge coincident with clearing read
    op(1'b1, 1'b0, 1'b1, 8'h00);
    check("R6 old value", reg_rdata, 8'h00);
    src_irq = 8'h10;
    op(1'b1, 1'b0, 1'b1, 8'h00);
    check("R6 edge kept", reg_rdata, 8'h10);
    src_irq = 8'h00;
    idle();

    // R8, R9 control layout with enables off
    src_en = 8'h00;
    op(1'b0, 1'b1, 1'b0, 8'hFF);
    op(1'b1, 1'b0, 1'b0, 8'h00);
    check("R9 rsvd readback", reg_rdata, 8'hBF);
    check("R8 pins all", ctl_pins(), 8'h3F);
    op(1'b1, 1'b0, 1'b1, 8'h00);
    check("R10 disabled under force", reg_rdata, 8'h00);
    op(1'b0, 1'b1, 1'b0, 8'h0A);
    op(1'b1, 1'b0, 1'b0, 8'h00);
    check("R8 readback 0A", reg_rdata, 8'h0A);
    check("R8 pins 0A", ctl_pins(), 8'h14);
    op(1'b0, 1'b1, 1'b0, 8'h30);
    op(1'b1, 1'b0, 1'b0, 8'h00);
    check("R8 spare readback", reg_rdata, 8'h30);
    check("R8 spare pins", ctl_pins(), 8'h03);
    op(1'b0, 1'b1, 1'b0, 8'h00);

    // R10 force
    src_en = 8'h0F; src_irq = '0;
    op(1'b1, 1'b0, 1'b1, 8'h00);
    op(1'b0, 1'b1, 1'b0, 8'h80);
    idle();
    op(1'b1, 1'b0, 1'b1, 8'h00); check("R10 forced", reg_rdata, 8'h0F);
    op(1'b1, 1'b0, 1'b1, 8'h00); check("R10 held over read", reg_rdata, 8'h0F);
    op(1'b0, 1'b1, 1'b0, 8'h00);
    op(1'b1, 1'b0, 1'b1, 8'h00); check("R10 kept after release", reg_rdata, 8'h0F);
    op(1'b1, 1'b0, 1'b1, 8'h00); check("R10 cleared", reg_rdata, 8'h00);
    check("R10 irq low", {7'd0, irq_o}, 8'h00);

    // R11 writes to status ignored
    src_en = 8'hFF; src_irq = '0;
    idle();
    src_irq = 8'h04;
    op(1'b0, 1'b1, 1'b1, 8'h00);
    op(1'b0, 1'b1, 1'b1, 8'hFF);
    op(1'b1, 1'b0, 1'b0, 8'h00); check("R11 ctrl untouched", reg_rdata, 8'h00);
    op(1'b1, 1'b0, 1'b1, 8'h00); check("R11 status kept", reg_rdata, 8'h04);
    src_irq = '0;
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule